// File: doc/BRIEF.md
# Six-Channel PWM Bank with Mode-Gated Polarity

The block produces six independent pulse-width-modulated outputs from one clock. A shared prescaler makes a tick every `DIV` clocks, and each channel counts ticks. The width register of a channel sets how many ticks one period lasts. The threshold register sets how many ticks at the start of the period the raw output stays high. Software writes every register through a single synchronous write port. The same register set is read back through a combinational read port, which also shows the live level of every output.

Polarity has no bit of its own in the channel registers. It comes only from a shared mode word. That word holds a global mode enable, a base-mode bit, an auxiliary-mode bit and an invert bit for each channel. A channel is inverted only when all four are in the right state. The block rejects an attempt to set base and auxiliary mode together on one channel: it keeps base mode and sets a sticky error flag. New width and threshold values are held in shadow registers and move into the counter path only at a period boundary, so a write in the middle of a period never cuts a pulse short.

Top module: `pwm_bank`

## Requirements
- R1: With normal polarity and width W ≥ 1, a channel's period lasts W ticks. The output is high for the first min(T, W) ticks and low for the rest, where T is the threshold. T = 0 keeps the output low, and T ≥ W keeps it high for the whole period.
- R2: Register addresses are: 0 for the enable register, with bit n enabling channel n; 1 for the mode word; 2 for status; 4+2n for the width of channel n; 5+2n for the threshold of channel n.
- R3: A disabled channel drives its idle level. The idle level is low when the channel is not inverted and high when it is inverted.
- R4: The output of channel n is inverted only when mode bit 0 (global), mode bit 16+n (auxiliary) and mode bit n+1 (invert) are all 1 and mode bit 8+n (base) is 0. Every other combination leaves the output uninverted, and a change to the mode word acts at once.
- R5: A mode write that sets both bit 8+n and bit 16+n stores bit 16+n as 0 and sets a sticky error flag. The flag reads at status bit 8 and is cleared only by reset.
- R6: A new width or threshold takes effect only at the next period boundary. A high phase that is already running keeps its old length.
- R7: Status bits 5..0 return the live level of outputs 5..0.
- R8: A seventh channel does not exist. Its width and threshold addresses (16 and 17) read 0 and ignore writes. Enable bit 6 and every mode bit that belongs to a channel index above 5 read 0.
- R9: After reset all registers read 0, the error flag is clear and every output is low.
- R10: The channel counters advance once every DIV clocks, so one tick lasts DIV clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 5 | Read address |
| rd_data | output | 32 | Combinational read data |
| pwm_out | output | 6 | Channel outputs |

## Verification
The assertions assume that a disabled channel whose mode logic is off must sit low. They also assume that the stored mode word never holds base and auxiliary mode together. The stimulus writes illegal mode words on purpose, so the sanitising path is exercised while that invariant is observed. Reads of the status address and of the absent channel's address appear in the stimulus only through the normal read port, and the checker compares them with the output pins. Duty is measured over windows of exactly one period, placed at least two periods after the last register write. This keeps every measurement clear of the boundary-deferred update.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
    localparam int ADDR_W    = 5;
    localparam int DATA_W    = 32;
    localparam int CNT_W     = 16;
    localparam int GLB_BIT   = 0;
    localparam int INV_BASE  = 1;
    localparam int BASE_BASE = 8;
    localparam int AUX_BASE  = 16;
    localparam int ERR_BIT   = 8;
    localparam int CH_BASE   = 4;

    typedef enum logic [ADDR_W-1:0] {
        A_ENABLE = 5'd0,
        A_MODE   = 5'd1,
        A_STATUS = 5'd2
    } ctrl_addr_e;

    typedef struct packed {
        logic [CNT_W-1:0] width;
        logic [CNT_W-1:0] thr;
    } chan_cfg_t;

    typedef struct packed {
        logic [DATA_W-1:0] word;
        logic              bad;
    } mode_fix_t;

    function automatic logic [DATA_W-1:0] mode_mask(input int nch);
        logic [DATA_W-1:0] m;
        m = '0;
        m[GLB_BIT] = 1'b1;
        for (int n = 0; n < nch; n++) begin
            m[INV_BASE+n]  = 1'b1;
            m[BASE_BASE+n] = 1'b1;
            m[AUX_BASE+n]  = 1'b1;
        end
        return m;
    endfunction

    function automatic mode_fix_t mode_sanitize(input logic [DATA_W-1:0] raw, input int nch);
        mode_fix_t r;
        r.word = raw & mode_mask(nch);
        r.bad  = 1'b0;
        for (int n = 0; n < nch; n++) begin
            if (r.word[BASE_BASE+n] && r.word[AUX_BASE+n]) begin
                r.word[AUX_BASE+n] = 1'b0;
                r.bad = 1'b1;
            end
        end
        return r;
    endfunction

    function automatic logic chan_inverted(input logic [DATA_W-1:0] mode, input int n);
        return mode[GLB_BIT] & mode[AUX_BASE+n] & ~mode[BASE_BASE+n] & mode[INV_BASE+n];
    endfunction
endpackage

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_every
            assign tick = 1'b1;
        end else begin : g_div
            localparam int PW = $clog2(DIV);
            logic [PW-1:0] pcnt;
            always_ff @(posedge clk) begin
                if (rst || pcnt == PW'(DIV-1)) pcnt <= '0;
                else                           pcnt <= pcnt + 1'b1;
            end
            assign tick = (pcnt == PW'(DIV-1));
        end
    endgenerate
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
    import pwm_bank_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      en,
    input  logic      inv,
    input  chan_cfg_t shadow,
    output logic      lvl
);
    chan_cfg_t        act;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   nxt;
    logic             wrap;

    assign nxt  = {1'b0, cnt} + 1'b1;
    assign wrap = (nxt >= {1'b0, act.width});

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            act <= '0;
        end else if (!en) begin
            cnt <= '0;
            act <= shadow;
        end else if (tick) begin
            if (wrap) begin
                cnt <= '0;
                act <= shadow;
            end else begin
                cnt <= nxt[CNT_W-1:0];
            end
        end
    end

    assign lvl = (en && (cnt < act.thr)) ^ inv;
endmodule

// File: rtl/pwm_ctrl_regs.sv
module pwm_ctrl_regs
    import pwm_bank_pkg::*;
#(
    parameter int NCH = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [NCH-1:0]    lvl,
    output logic [NCH-1:0]    en_q,
    output logic [DATA_W-1:0] mode_q,
    output logic              err_q,
    output chan_cfg_t         cfg_q [NCH]
);
    mode_fix_t fix;
    assign fix = mode_sanitize(wr_data, NCH);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            mode_q <= '0;
            err_q  <= 1'b0;
            for (int n = 0; n < NCH; n++) cfg_q[n] <= '0;
        end else if (wr_en) begin
            if (wr_addr == A_ENABLE) en_q <= wr_data[NCH-1:0];
            if (wr_addr == A_MODE) begin
                mode_q <= fix.word;
                if (fix.bad) err_q <= 1'b1;
            end
            for (int n = 0; n < NCH; n++) begin
                if (wr_addr == ADDR_W'(CH_BASE + 2*n))
                    cfg_q[n].width <= wr_data[CNT_W-1:0];
                if (wr_addr == ADDR_W'(CH_BASE + 2*n + 1))
                    cfg_q[n].thr <= wr_data[CNT_W-1:0];
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == A_ENABLE) rd_data[NCH-1:0] = en_q;
        if (rd_addr == A_MODE)   rd_data = mode_q;
        if (rd_addr == A_STATUS) begin
            rd_data[NCH-1:0] = lvl;
            rd_data[ERR_BIT] = err_q;
        end
        for (int n = 0; n < NCH; n++) begin
            if (rd_addr == ADDR_W'(CH_BASE + 2*n))
                rd_data[CNT_W-1:0] = cfg_q[n].width;
            if (rd_addr == ADDR_W'(CH_BASE + 2*n + 1))
                rd_data[CNT_W-1:0] = cfg_q[n].thr;
        end
    end
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
    import pwm_bank_pkg::*;
#(
    parameter int NCH = 6,
    parameter int DIV = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [NCH-1:0]    pwm_out
);
    logic              tick;
    logic [NCH-1:0]    en_q;
    logic [DATA_W-1:0] mode_q;
    logic              err_q;
    chan_cfg_t         cfg_q [NCH];

    pwm_tick_gen #(.DIV(DIV)) tick_i (
        .clk (clk),
        .rst (rst),
        .tick(tick)
    );

    pwm_ctrl_regs #(.NCH(NCH)) regs_i (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .rd_addr(rd_addr),
        .rd_data(rd_data),
        .lvl    (pwm_out),
        .en_q   (en_q),
        .mode_q (mode_q),
        .err_q  (err_q),
        .cfg_q  (cfg_q)
    );

    generate
        for (genvar n = 0; n < NCH; n++) begin : g_ch
            pwm_chan chan_i (
                .clk   (clk),
                .rst   (rst),
                .tick  (tick),
                .en    (en_q[n]),
                .inv   (chan_inverted(mode_q, n)),
                .shadow(cfg_q[n]),
                .lvl   (pwm_out[n])
            );
        end
    endgenerate
endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk
    import pwm_bank_pkg::*;
#(
    parameter int NCH = 6
) (
    input logic              clk,
    input logic              rst,
    input logic [NCH-1:0]    en_q,
    input logic [DATA_W-1:0] mode_q,
    input logic              err_q,
    input logic [NCH-1:0]    pwm_out,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [DATA_W-1:0] rd_data
);
    generate
        for (genvar n = 0; n < NCH; n++) begin : g_p
            p_idle_low_r3: assert property (@(posedge clk) disable iff (rst)
                (!en_q[n] && !mode_q[GLB_BIT]) |-> !pwm_out[n]);
            p_no_aux_no_inv_r4: assert property (@(posedge clk) disable iff (rst)
                (!en_q[n] && !mode_q[AUX_BASE+n]) |-> !pwm_out[n]);
            p_mode_excl_r5: assert property (@(posedge clk) disable iff (rst)
                !(mode_q[BASE_BASE+n] && mode_q[AUX_BASE+n]));
        end
    endgenerate

    p_err_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        err_q |=> err_q);
    p_status_live_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_addr == A_STATUS) |-> (rd_data[NCH-1:0] == pwm_out));
    p_absent_w_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_addr == ADDR_W'(CH_BASE + 2*NCH)) |-> (rd_data == '0));
    p_absent_t_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_addr == ADDR_W'(CH_BASE + 2*NCH + 1)) |-> (rd_data == '0));
    p_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (en_q == '0 && !mode_q[GLB_BIT]) |-> (pwm_out == '0));
endmodule

bind pwm_bank pwm_bank_chk #(.NCH(NCH)) chk_i (
    .clk    (clk),
    .rst    (rst),
    .en_q   (en_q),
    .mode_q (mode_q),
    .err_q  (err_q),
    .pwm_out(pwm_out),
    .rd_addr(rd_addr),
    .rd_data(rd_data)
);

// File: tb/pwm_bank_tb_top.sv
`timescale 1ns/1ps
module pwm_bank_tb_top;
    localparam int NCH = 6;
    localparam int DIV = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [4:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [5:0]  pwm_out;

    int checks = 0;
    int errors = 0;
    int hi [NCH];
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pwm_bank #(.NCH(NCH), .DIV(DIV)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .pwm_out(pwm_out)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 5'(a); wr_data = 32'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        rd_addr = 5'(a);
        #0.5;
        d = int'(rd_data);
    endtask

    task automatic measure(input int cyc);
        for (int i = 0; i < NCH; i++) hi[i] = 0;
        for (int c = 0; c < cyc; c++) begin
            @(negedge clk);
            for (int i = 0; i < NCH; i++) hi[i] += int'(pwm_out[i]);
        end
    endtask

    initial begin
        #(200000 * 5.0);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int d;
        int ws [4];
        int run;
        ws = '{1, 3, 5, 8};
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R9: reset state
        chk(pwm_out == 6'd0, "R9 outputs", pwm_out, 0);
        for (int a = 0; a < 18; a++) begin
            rd(a, d);
            chk(d == 0, "R9 register", d, 0);
        end

        // R1, R10: duty sweep on all channels
        wr(0, 32'h3F);
        foreach (ws[k]) begin
            for (int t = 0; t <= ws[k] + 1; t++) begin
                for (int c = 0; c < NCH; c++) begin
                    wr(4 + 2*c, ws[k]);
                    wr(5 + 2*c, (t + c) % (ws[k] + 2));
                end
                repeat (2 * ws[k] * DIV + 4) @(negedge clk);
                measure(ws[k] * DIV);
                for (int c = 0; c < NCH; c++) begin
                    int tt, e;
                    tt = (t + c) % (ws[k] + 2);
                    e = ((tt < ws[k]) ? tt : ws[k]) * DIV;
                    chk(hi[c] == e, "R1/R10 high cycles per period", hi[c], e);
                end
            end
        end

        // R4, R5: mode truth table on channel 2 (W=4, T=1)
        wr(8, 4); wr(9, 1);
        repeat (20) @(negedge clk);
        rd(2, d);
        chk(d[8] == 1'b0, "R5 error clear before illegal write", d[8], 0);
        for (int i = 0; i < 16; i++) begin
            int m, exp_m;
            bit g, iv, bs, ax, inv;
            g = i[0]; iv = i[1]; bs = i[2]; ax = i[3];
            m = (int'(g) << 0) | (int'(iv) << 3) | (int'(bs) << 10) | (int'(ax) << 18);
            wr(1, m);
            inv = g && ax && !bs && iv;
            measure(4 * DIV);
            chk(hi[2] == (inv ? 6 : 2), "R4 inversion gating", hi[2], inv ? 6 : 2);
            exp_m = m & ~((bs && ax) ? (1 << 18) : 0);
            rd(1, d);
            chk(d == exp_m, "R5 mode readback", d, exp_m);
            rd(2, d);
            chk(d[8] == (i >= 12), "R5 sticky error", d[8], i >= 12);
        end

        // R3: idle level of a disabled channel
        wr(1, 32'h40009);
        wr(0, 32'h3B);
        measure(8);
        chk(hi[2] == 8, "R3 idle high when inverted", hi[2], 8);
        rd(2, d);
        chk(d[2] == 1'b1, "R7 status shows channel 2 high", d[2], 1);
        wr(1, 0);
        measure(8);
        chk(hi[2] == 0, "R3 idle low when not inverted", hi[2], 0);
        rd(2, d);
        chk(d[2] == 1'b0, "R7 status shows channel 2 low", d[2], 0);

        // R6: threshold change mid-period on channel 0 (W=8, T=4)
        wr(4, 8); wr(5, 4);
        repeat (40) @(negedge clk);
        while (pwm_out[0] != 1'b0) @(negedge clk);
        while (pwm_out[0] != 1'b1) @(negedge clk);
        wr_en = 1'b1; wr_addr = 5'd5; wr_data = 32'd1;
        @(negedge clk);
        wr_en = 1'b0;
        chk(pwm_out[0] == 1'b1, "R6 pulse not cut after write", pwm_out[0], 1);
        run = 2;
        @(negedge clk);
        while (pwm_out[0] == 1'b1) begin run++; @(negedge clk); end
        chk(run == 8, "R6 running high phase keeps old length", run, 8);
        while (pwm_out[0] != 1'b1) @(negedge clk);
        run = 0;
        while (pwm_out[0] == 1'b1) begin run++; @(negedge clk); end
        chk(run == DIV, "R6 new threshold after boundary", run, DIV);

        // R8, R2: absent channel and unused bits
        wr(16, 32'h1234); wr(17, 32'h55);
        rd(16, d); chk(d == 0, "R8 absent width", d, 0);
        rd(17, d); chk(d == 0, "R8 absent threshold", d, 0);
        wr(0, 32'h7F);
        rd(0, d); chk(d == 32'h3F, "R8 enable bit 6 ignored", d, 32'h3F);
        wr(1, 32'hFFFF_FFFF);
        rd(1, d); chk(d == 32'h3F7F, "R8/R5 mode mask and fallback", d, 32'h3F7F);
        rd(14, d); chk(d == 8, "R2 channel 5 width address", d, 8);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule